// File: doc/BRIEF.md
# SHA-512 Block Compression Engine (Five Rounds per Clock)

This core applies the SHA-512 compression function to one 1024-bit message block that the caller has already padded. It keeps a 512-bit chaining value between blocks. A start pulse with the first-block flag set seeds the chaining value with the standard SHA-512 initial hash before compressing. With the flag clear, the block is compressed on top of whatever the previous block left.

The datapath chains five rounds in combinational logic each clock, so the 80 rounds take 16 iterations. A message-schedule window of sixteen 64-bit words extends itself by five words per iteration. The 80 round constants are computed at elaboration from the cube roots of the first 80 primes, not typed in as a table. One more cycle adds the working variables into the chaining value. That sum appears on the digest output together with a one-cycle done pulse.

Top module: `sha512_core`

## Requirements
- R1: While and after synchronous reset, with no block run yet, `busy` and `done` are low and `digest` is all zeros.
- R2: Word t (t = 0..15) of the block is `block_in[1023-64t -: 64]`. Chaining word Hk is reported at `digest[511-64k -: 64]`. A correctly padded one-block message run with `first_blk` high yields its SHA-512 digest, for example that of "abc".
- R3: A run with `first_blk` high starts from the standard initial hash value, whatever chaining value earlier blocks left. The empty message gives its standard digest right after a different message.
- R4: A run with `first_blk` low continues from the chaining value of the previous run. Two consecutive blocks of a two-block message yield that message's digest.
- R5: `done` rises exactly 17 clock edges after the edge that accepts `start`. `busy` is high from the cycle after acceptance until `done` is raised.
- R6: `done` stays high for exactly one cycle per accepted block.
- R7: `digest` changes only in the cycle `done` is raised. It holds through idle cycles and through the whole of the next run.
- R8: `start` is ignored while `busy` is high, including the final-addition cycle. `block_in` and `first_blk` are captured only at acceptance and may change afterwards without effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to compress `block_in`; accepted when `busy` is low |
| first_blk | input | 1 | At acceptance: seed chaining value with the initial hash |
| block_in | input | 1024 | Padded message block, word 0 in the top bits |
| busy | output | 1 | A block is being compressed |
| digest | output | 512 | Chaining value after the last completed block, H0 in the top bits |
| done | output | 1 | One-cycle pulse when `digest` has been updated |

## Verification
The hardest situation to reach is a start request during the final-addition cycle, when `busy` is still high but the rounds are over. The bench holds `start` high for the entire run of a block while it replaces `block_in` and `first_blk` with other values. The digest must still be the one for the original block, and no second run may begin once `done` has been seen. Chaining across blocks is reached through a real two-block message whose padded blocks the bench builds from its character pattern. Reseeding is reached by running a one-block message right after that two-block message.

// File: rtl/sha512_pkg.sv
package sha512_pkg;
  localparam int WORD_W  = 64;
  localparam int NROUNDS = 80;
  localparam int WIN_N   = 16;
  localparam int HS_N    = 8;

  typedef logic [WORD_W-1:0]            word_t;
  typedef logic [0:HS_N-1][WORD_W-1:0]  hstate_t;
  typedef logic [0:WIN_N-1][WORD_W-1:0] wwin_t;

  localparam hstate_t HASH_INIT = {
    64'h6a09e667f3bcc908, 64'hbb67ae8584caa73b,
    64'h3c6ef372fe94f82b, 64'ha54ff53a5f1d36f1,
    64'h510e527fade682d1, 64'h9b05688c2b3e6c1f,
    64'h1f83d9abfb41bd6b, 64'h5be0cd19137e2179};

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t bsig0(input word_t x);
    return rotr(x, 28) ^ rotr(x, 34) ^ rotr(x, 39);
  endfunction

  function automatic word_t bsig1(input word_t x);
    return rotr(x, 14) ^ rotr(x, 18) ^ rotr(x, 41);
  endfunction

  function automatic word_t ssig0(input word_t x);
    return rotr(x, 1) ^ rotr(x, 8) ^ (x >> 7);
  endfunction

  function automatic word_t ssig1(input word_t x);
    return rotr(x, 19) ^ rotr(x, 61) ^ (x >> 6);
  endfunction

  // Round constant t: low 64 bits of floor(cbrt(p * 2^192)), p the t-th prime.
  function automatic word_t round_const(input int t);
    int          cnt;
    int          prime;
    logic        is_p;
    logic [255:0] target;
    logic [255:0] cube;
    logic [66:0]  root;
    logic [66:0]  cand;
    cnt   = 0;
    prime = 2;
    for (int n = 2; n < 420; n++) begin
      is_p = 1'b1;
      for (int d = 2; d * d <= n; d++)
        if (n % d == 0) is_p = 1'b0;
      if (is_p) begin
        if (cnt == t) prime = n;
        cnt++;
      end
    end
    target = 256'(prime) << 192;
    root   = '0;
    for (int b = 66; b >= 0; b--) begin
      cand = root | (67'd1 << b);
      cube = 256'(cand) * 256'(cand) * 256'(cand);
      if (cube <= target) root = cand;
    end
    return root[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/sha512_kconst.sv
module sha512_kconst
  import sha512_pkg::*;
#(
  parameter int UNROLL = 5,
  localparam int IDX_W = $clog2(NROUNDS)
) (
  input  logic [IDX_W-1:0]             base_i,
  output logic [0:UNROLL-1][WORD_W-1:0] k_o
);
  word_t rom [0:NROUNDS-1];

  for (genvar t = 0; t < NROUNDS; t++) begin : g_rom
    localparam word_t KVAL = round_const(t);
    assign rom[t] = KVAL;
  end

  for (genvar j = 0; j < UNROLL; j++) begin : g_rd
    logic [IDX_W-1:0] idx;
    assign idx    = base_i + IDX_W'(j);
    assign k_o[j] = rom[idx];
  end
endmodule

// File: rtl/sha512_sched.sv
module sha512_sched
  import sha512_pkg::*;
#(
  parameter int UNROLL = 5
) (
  input  wwin_t win_i,
  output wwin_t win_o
);
  word_t ext [0:WIN_N+UNROLL-1];

  for (genvar i = 0; i < WIN_N; i++) begin : g_old
    assign ext[i] = win_i[i];
  end

  // New words may depend on words produced earlier in the same cycle.
  for (genvar j = 0; j < UNROLL; j++) begin : g_new
    assign ext[WIN_N+j] = ssig1(ext[WIN_N-2+j]) + ext[WIN_N-7+j]
                        + ssig0(ext[j+1]) + ext[j];
  end

  for (genvar i = 0; i < WIN_N; i++) begin : g_out
    assign win_o[i] = ext[UNROLL+i];
  end
endmodule

// File: rtl/sha512_round.sv
module sha512_round
  import sha512_pkg::*;
(
  input  hstate_t st_i,
  input  word_t   k_i,
  input  word_t   w_i,
  output hstate_t st_o
);
  word_t va, vb, vc, vd, ve, vf, vg, vh;
  word_t sum1, sum2, choose, major;

  always_comb begin
    {va, vb, vc, vd, ve, vf, vg, vh} = st_i;
    choose = (ve & vf) ^ (~ve & vg);
    major  = (va & vb) ^ (va & vc) ^ (vb & vc);
    sum1   = vh + bsig1(ve) + choose + k_i + w_i;
    sum2   = bsig0(va) + major;
    st_o   = {sum1 + sum2, va, vb, vc, vd + sum1, ve, vf, vg};
  end
endmodule

// File: rtl/sha512_core.sv
module sha512_core
  import sha512_pkg::*;
#(
  parameter int UNROLL = 5,              // must divide 80
  localparam int ITERS  = NROUNDS / UNROLL,
  localparam int ITER_W = $clog2(ITERS),
  localparam int IDX_W  = $clog2(NROUNDS),
  localparam int BLK_W  = WORD_W * WIN_N,
  localparam int DIG_W  = WORD_W * HS_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             first_blk,
  input  logic [BLK_W-1:0] block_in,
  output logic             busy,
  output logic [DIG_W-1:0] digest,
  output logic             done
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} fsm_t;

  fsm_t              fsm;
  logic [ITER_W-1:0] iter;
  hstate_t           work, chain, fed;
  wwin_t             win, win_nx;
  logic [0:UNROLL-1][WORD_W-1:0] kv;
  hstate_t           st [0:UNROLL];
  logic [IDX_W-1:0]  kbase;

  assign kbase = IDX_W'(iter) * IDX_W'(UNROLL);

  sha512_kconst #(.UNROLL(UNROLL)) u_kconst (
    .base_i (kbase),
    .k_o    (kv)
  );

  sha512_sched #(.UNROLL(UNROLL)) u_sched (
    .win_i (win),
    .win_o (win_nx)
  );

  assign st[0] = work;
  for (genvar j = 0; j < UNROLL; j++) begin : g_rnd
    sha512_round u_round (
      .st_i (st[j]),
      .k_i  (kv[j]),
      .w_i  (win[j]),
      .st_o (st[j+1])
    );
  end

  always_comb begin
    for (int i = 0; i < HS_N; i++) fed[i] = chain[i] + work[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm    <= S_IDLE;
      iter   <= '0;
      work   <= '0;
      chain  <= '0;
      win    <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      digest <= '0;
    end else begin
      done <= 1'b0;
      case (fsm)
        S_IDLE: begin
          if (start) begin
            work  <= first_blk ? HASH_INIT : chain;
            chain <= first_blk ? HASH_INIT : chain;
            win   <= block_in;
            iter  <= '0;
            busy  <= 1'b1;
            fsm   <= S_RUN;
          end
        end
        S_RUN: begin
          work <= st[UNROLL];
          win  <= win_nx;
          iter <= iter + 1'b1;
          if (iter == ITER_W'(ITERS - 1)) fsm <= S_FIN;
        end
        S_FIN: begin
          chain  <= fed;
          digest <= fed;
          done   <= 1'b1;
          busy   <= 1'b0;
          fsm    <= S_IDLE;
        end
        default: fsm <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sha512_core_chk.sv
module sha512_core_chk #(
  parameter int ITERS = 16,
  parameter int DIG_W = 512
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [DIG_W-1:0] digest
);
  logic [7:0] lat;

  always_ff @(posedge clk) begin
    if (rst)                lat <= '0;
    else if (start && !busy) lat <= '0;
    else if (busy)          lat <= lat + 8'd1;
  end

  // R5: accepted start raises busy on the next cycle
  a_r5_busy_on_accept: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R5: done arrives exactly ITERS+1 edges after acceptance
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat == 8'(ITERS + 1)));

  // R5: busy only drops together with done
  a_r5_busy_ends: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: digest moves only when done is raised
  a_r7_digest_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(digest));

  // R8: done is never seen with busy still high
  a_r8_idle_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind sha512_core sha512_core_chk #(.ITERS(16), .DIG_W(512)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .digest (digest)
);

// File: tb/test_sha512_core.sv
module test_sha512_core;
  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          first_blk = 1'b0;
  logic [1023:0] block_in = '0;
  logic          busy;
  logic [511:0]  digest;
  logic          done;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  sha512_core i_sha512_core (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .first_blk (first_blk),
    .block_in  (block_in),
    .busy      (busy),
    .digest    (digest),
    .done      (done)
  );

  localparam logic [511:0] D_ABC =
    512'hddaf35a193617abacc417349ae20413112e6fa4e89a97ea20a9eeee64b55d39a2192992a274fc1a836ba3c23a3feebbd454d4423643ce80e2a9ac94fa54ca49f;
  localparam logic [511:0] D_EMPTY =
    512'hcf83e1357eefb8bdf1542850d66d8007d620e4050b5715dc83f4a921d36ce9ce47d0d13c5d85f2b0ff8318d2877eec2f63b931bd47417a81a538327af927da3e;
  localparam logic [511:0] D_TWO =
    512'h8e959b75dae313da8cf4f72814fc143f8f7779c6eb9f7fa17299aeadb6889018501d289e4900f7e4331b99dec4b5433ac7d329eeb6dd26545e96e55b874be909;

  // entry: {message kind[1:0], first_blk, check digest, expected digest}
  // kinds: 0 "abc", 1 empty, 2 long message block 1, 3 long message block 2
  localparam logic [515:0] VEC [5] = '{
    {2'd2, 1'b1, 1'b0, 512'h0},
    {2'd3, 1'b0, 1'b1, D_TWO},
    {2'd0, 1'b1, 1'b1, D_ABC},
    {2'd1, 1'b1, 1'b1, D_EMPTY},
    {2'd0, 1'b1, 1'b1, D_ABC}
  };

  function automatic logic [1023:0] make_block(input logic [1:0] kind);
    logic [1023:0] b;
    b = '0;
    case (kind)
      2'd0: begin
        b[1023 -: 32] = 32'h61626380;
        b[7:0]        = 8'h18;
      end
      2'd1: b[1023 -: 8] = 8'h80;
      2'd2: begin
        for (int g = 0; g < 14; g++)
          for (int i = 0; i < 8; i++)
            b[1023 - 8*(g*8+i) -: 8] = 8'(8'h61 + g + i);
        b[1023 - 8*112 -: 8] = 8'h80;
      end
      default: b[15:0] = 16'h0380;
    endcase
    return b;
  endfunction

  task automatic chk(input string tag, input logic ok, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Accept a block, then scramble inputs; returns digest, latency, done width.
  task automatic run_blk(input logic f, input logic [1023:0] b, input logic hold_start,
                         output logic [511:0] d, output int lat, output logic after);
    @(negedge clk);
    first_blk = f;
    block_in  = b;
    start     = 1'b1;
    @(posedge clk); #1;
    chk("R5 busy after accept", busy === 1'b1, 512'(busy), 512'd1);
    @(negedge clk);
    start     = hold_start;
    block_in  = ~b;
    first_blk = ~f;
    lat = 0;
    while (done !== 1'b1 && lat < 100) begin
      @(posedge clk); #1;
      lat++;
    end
    d = digest;
    @(negedge clk);
    start = 1'b0;
    @(posedge clk); #1;
    after = done;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [511:0] d;
    logic [511:0] keep;
    int           lat;
    logic         after;

    repeat (3) @(posedge clk);
    #1;
    chk("R1 busy in reset", busy === 1'b0, 512'(busy), 512'd0);
    chk("R1 done in reset", done === 1'b0, 512'(done), 512'd0);
    chk("R1 digest in reset", digest === '0, digest, 512'd0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 digest after reset", digest === '0, digest, 512'd0);

    // Table walk: R2 one-block, R4 chaining, R3 reseed after other data
    for (int v = 0; v < 5; v++) begin
      run_blk(VEC[v][513], make_block(VEC[v][515:514]), 1'b0, d, lat, after);
      if (VEC[v][512])
        chk($sformatf("R2/R3/R4 digest vector %0d", v), d === VEC[v][511:0], d, VEC[v][511:0]);
      chk("R5 latency", lat == 17, 512'(lat), 512'd17);
      chk("R6 done one cycle", after === 1'b0, 512'(after), 512'd0);
    end

    // R7: digest holds over idle cycles
    keep = digest;
    repeat (7) @(posedge clk);
    #1;
    chk("R7 digest idle hold", digest === keep, digest, keep);

    // R7: digest holds during the next run
    @(negedge clk);
    first_blk = 1'b1;
    block_in  = make_block(2'd1);
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(posedge clk);
    #1;
    chk("R7 digest hold mid-run", digest === keep, digest, keep);
    while (done !== 1'b1) begin
      @(posedge clk); #1;
    end
    chk("R3 empty after abc", digest === D_EMPTY, digest, D_EMPTY);

    // R8: start held high through the whole run, inputs replaced
    run_blk(1'b1, make_block(2'd0), 1'b1, d, lat, after);
    chk("R8 digest ignores late start", d === D_ABC, d, D_ABC);
    chk("R8 latency with start held", lat == 17, 512'(lat), 512'd17);
    chk("R8 no second run", busy === 1'b0, 512'(busy), 512'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule